// File: doc/BRIEF.md
# Interrupt Context Register Window

This block sits beside the interrupt arbiter of a multi-channel serial controller and gives the host a set of fixed-address registers whose meaning follows the interrupt context frozen at the last capture. A capture happens when the host issues an update command or when an interrupt acknowledge cycle begins. At that moment the block latches the winning source's kind, its three-bit other-type code, its channel and a byte count. For a transmit source the count is the free space of that channel's transmit queue. For a receive source it is the fill level of that channel's receive queue.

Between captures the host reads the channel, count and type registers. It also uses one receive data port and one transmit data port, and both are steered to the captured channel. The host therefore needs no per-channel addresses while it serves an interrupt. During an acknowledge cycle the block drives an interrupt vector built from a stored byte. A two-bit control field chooses whether the channel and kind are patched into the vector, or whether no vector is driven at all.

Top module: `gwin_ctx_window`

## Requirements
- R1: After reset the captured context is kind 00, code 0, channel 0 and count 0. The stored vector byte is 0x00 and the vector is not driven.
- R2: The context is captured only at the clock edge where `ucir_i` is high or where `iack_i` is high after being low in the previous cycle. At every other edge the context holds, even while `iack_i` stays high or the arbiter inputs change.
- R3: A read at address 0 returns the captured channel in bit 0 and zeros in bits 7:1.
- R4: A read at address 1 returns the count latched at capture: the transmit free level for kind 01, the receive fill level for kinds 10 and 11, and 0 for kind 00. The count is taken modulo 256, so a level of 256 reads 0x00. Level changes after the capture do not alter the count.
- R5: A read at address 2 returns the type byte. Bits 7:6 are 10 for kind 11 (receive with errors), 11 for kind 10 (receive without errors) and 00 otherwise. Bit 5 is 1 only for kind 01 (transmit). Bits 4:3 are 0. Bits 2:0 hold the other-type code for kind 00 and are 000 for every other kind.
- R6: A read at address 3 returns the head byte of the captured channel's receive queue, with unused upper bits zeroed according to that channel's 2-bit length code (00 = 5 bits, 01 = 6, 10 = 7, 11 = 8). The same read pulses `rx_pop_o` for that channel only.
- R7: A write at address 4 pulses `tx_push_o` for the captured channel only and presents the write data on `tx_wdata_o`.
- R8: A write at address 5 stores the vector byte, and a read at address 5 returns it.
- R9: With the vector control field at 00, `vec_oe_o` stays low through an acknowledge cycle.
- R10: With the field at 01, the vector equals the stored byte unchanged.
- R11: With the field at 10, vector bit 0 is replaced by the captured channel and the other bits are the stored byte.
- R12: With the field at 11, vector bit 0 is replaced by the channel and bits 2:1 by the captured kind code. Bits 7:3 stay as stored.
- R13: `vec_oe_o` is high in a cycle only if `iack_i` was high in the previous cycle and the field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ucir_i | input | 1 | Update command: capture the arbiter winner |
| iack_i | input | 1 | Interrupt acknowledge cycle in progress |
| vec_cfg_i | input | 2 | Vector control field |
| win_kind_i | input | 2 | Winner kind: 00 other, 01 transmit, 10 receive ok, 11 receive with errors |
| win_code_i | input | 3 | Winner other-type code |
| win_ch_i | input | CH_W | Winner channel |
| tx_empty_lvl_i | input | NUM_CH*LVL_W | Per-channel transmit free levels |
| rx_fill_lvl_i | input | NUM_CH*LVL_W | Per-channel receive fill levels |
| char_len_i | input | NUM_CH*2 | Per-channel character length code |
| rx_data_i | input | NUM_CH*8 | Per-channel receive queue head bytes |
| reg_addr_i | input | 3 | Register address |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| rx_pop_o | output | NUM_CH | Receive queue pop, one per channel |
| tx_push_o | output | NUM_CH | Transmit queue push, one per channel |
| tx_wdata_o | output | 8 | Data for the transmit queue |
| vec_oe_o | output | 1 | Vector drive enable |
| vec_o | output | 8 | Interrupt vector |

## Verification
The bench loads a level of exactly 256 into the count path. A design that saturated the count or kept a ninth bit would read 0xFF there, not 0x00. It holds `iack_i` high across several cycles while it changes the arbiter inputs. A design that captured on the level of the acknowledge rather than its start would show the new channel in the vector and the registers. The bench gives the two channels distinct data and lengths and checks the type byte against both receive kinds. A design that swapped the error encodings, masked with the wrong channel's length, or popped or pushed the wrong queue would show up there as a wrong byte or a wrong strobe.

// File: rtl/gwin_pkg.sv
package gwin_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER  = 2'b00,
    KIND_TX     = 2'b01,
    KIND_RX_OK  = 2'b10,
    KIND_RX_ERR = 2'b11
  } kind_e;

  localparam logic [2:0] A_CHAN   = 3'd0;
  localparam logic [2:0] A_COUNT  = 3'd1;
  localparam logic [2:0] A_TYPE   = 3'd2;
  localparam logic [2:0] A_RXPORT = 3'd3;
  localparam logic [2:0] A_TXPORT = 3'd4;
  localparam logic [2:0] A_VECTOR = 3'd5;

  // Type byte assembled from the captured kind and other-type code
  function automatic logic [7:0] type_byte(input logic [1:0] kind, input logic [2:0] code);
    logic [7:0] t;
    t = 8'h00;
    case (kind)
      KIND_RX_ERR: t[7:6] = 2'b10;
      KIND_RX_OK:  t[7:6] = 2'b11;
      KIND_TX:     t[5]   = 1'b1;
      default:     t[2:0] = code;
    endcase
    return t;
  endfunction

  // Zero the data bits a short character does not use
  function automatic logic [7:0] len_mask(input logic [7:0] d, input logic [1:0] len);
    logic [7:0] m;
    m = 8'hFF >> (2'd3 - len);
    return d & m;
  endfunction

  // Patch the stored vector according to the control field
  function automatic logic [7:0] patch_vec(input logic [7:0] base, input logic [1:0] cfg,
                                           input logic [1:0] kind, input logic ch);
    logic [7:0] v;
    v = base;
    if (cfg[1]) v[0] = ch;
    if (cfg == 2'b11) v[2:1] = kind;
    return v;
  endfunction

endpackage

// File: rtl/gwin_ctx_latch.sv
module gwin_ctx_latch
  import gwin_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LVL_W  = 9,
  parameter int CH_W   = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [1:0]              kind_i,
  input  logic [2:0]              code_i,
  input  logic [CH_W-1:0]         ch_i,
  input  logic [NUM_CH*LVL_W-1:0] tx_lvl_i,
  input  logic [NUM_CH*LVL_W-1:0] rx_lvl_i,
  output logic [1:0]              ctx_kind_o,
  output logic [2:0]              ctx_code_o,
  output logic [CH_W-1:0]         ctx_ch_o,
  output logic [7:0]              ctx_count_o
);

  logic [LVL_W-1:0] tx_sel, rx_sel, lvl_pick;

  always_comb begin
    tx_sel = '0;
    rx_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_i == CH_W'(c)) begin
        tx_sel = tx_lvl_i[c*LVL_W +: LVL_W];
        rx_sel = rx_lvl_i[c*LVL_W +: LVL_W];
      end
    end
    case (kind_i)
      KIND_TX:                lvl_pick = tx_sel;
      KIND_RX_OK, KIND_RX_ERR: lvl_pick = rx_sel;
      default:                lvl_pick = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_kind_o  <= 2'b00;
      ctx_code_o  <= 3'd0;
      ctx_ch_o    <= '0;
      ctx_count_o <= 8'h00;
    end else if (cap_i) begin
      ctx_kind_o  <= kind_i;
      ctx_code_o  <= code_i;
      ctx_ch_o    <= ch_i;
      ctx_count_o <= lvl_pick[7:0];
    end
  end

  AST_CTX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(ctx_ch_o) && $stable(ctx_kind_o) && $stable(ctx_count_o)); // R2
  AST_COUNT_ZERO_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && kind_i == KIND_OTHER) |=> ctx_count_o == 8'h00); // R4

endmodule

// File: rtl/gwin_fifo_steer.sv
module gwin_fifo_steer
  import gwin_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [7:0]          wdata_i,
  input  logic [CH_W-1:0]     ctx_ch_i,
  input  logic [NUM_CH*8-1:0] rx_data_i,
  input  logic [NUM_CH*2-1:0] char_len_i,
  output logic [NUM_CH-1:0]   rx_pop_o,
  output logic [NUM_CH-1:0]   tx_push_o,
  output logic [7:0]          tx_wdata_o,
  output logic [7:0]          rx_byte_o
);

  logic rx_hit, tx_hit;
  assign rx_hit = rd_i && (addr_i == A_RXPORT);
  assign tx_hit = wr_i && (addr_i == A_TXPORT);
  assign tx_wdata_o = wdata_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic sel;
    assign sel          = (ctx_ch_i == CH_W'(g));
    assign rx_pop_o[g]  = rx_hit && sel;
    assign tx_push_o[g] = tx_hit && sel;
  end

  always_comb begin
    rx_byte_o = 8'h00;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ctx_ch_i == CH_W'(c))
        rx_byte_o = len_mask(rx_data_i[c*8 +: 8], char_len_i[c*2 +: 2]);
    end
  end

  AST_POP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_pop_o)); // R6
  AST_POP_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_pop_o) |-> rd_i); // R6
  AST_PUSH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_push_o)); // R7

endmodule

// File: rtl/gwin_vec_drive.sv
module gwin_vec_drive
  import gwin_pkg::*;
#(
  parameter int CH_W = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            iack_i,
  input  logic [1:0]      cfg_i,
  input  logic [7:0]      ivr_i,
  input  logic [1:0]      ctx_kind_i,
  input  logic [CH_W-1:0] ctx_ch_i,
  output logic            ack_start_o,
  output logic            vec_oe_o,
  output logic [7:0]      vec_o
);

  logic iack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iack_q <= 1'b0;
    else         iack_q <= iack_i;
  end

  assign ack_start_o = iack_i && !iack_q;
  assign vec_oe_o    = iack_q && (cfg_i != 2'b00);
  assign vec_o       = vec_oe_o ? patch_vec(ivr_i, cfg_i, ctx_kind_i, ctx_ch_i[0]) : 8'h00;

  AST_VEC_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 2'b00) |-> !vec_oe_o); // R9
  AST_VEC_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> vec_o[7:3] == ivr_i[7:3]); // R12
  AST_VEC_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> $past(iack_i)); // R13

endmodule

// File: rtl/gwin_ctx_window.sv
module gwin_ctx_window
  import gwin_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int FIFO_DEPTH = 256,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ucir_i,
  input  logic                    iack_i,
  input  logic [1:0]              vec_cfg_i,
  input  logic [1:0]              win_kind_i,
  input  logic [2:0]              win_code_i,
  input  logic [CH_W-1:0]         win_ch_i,
  input  logic [NUM_CH*LVL_W-1:0] tx_empty_lvl_i,
  input  logic [NUM_CH*LVL_W-1:0] rx_fill_lvl_i,
  input  logic [NUM_CH*2-1:0]     char_len_i,
  input  logic [NUM_CH*8-1:0]     rx_data_i,
  input  logic [2:0]              reg_addr_i,
  input  logic                    reg_rd_i,
  input  logic                    reg_wr_i,
  input  logic [7:0]              reg_wdata_i,
  output logic [7:0]              reg_rdata_o,
  output logic [NUM_CH-1:0]       rx_pop_o,
  output logic [NUM_CH-1:0]       tx_push_o,
  output logic [7:0]              tx_wdata_o,
  output logic                    vec_oe_o,
  output logic [7:0]              vec_o
);

  logic            ack_start, capture;
  logic [1:0]      ctx_kind;
  logic [2:0]      ctx_code;
  logic [CH_W-1:0] ctx_ch;
  logic [7:0]      ctx_count;
  logic [7:0]      rx_byte;
  logic [7:0]      ivr_q;

  assign capture = ucir_i || ack_start;

  gwin_vec_drive #(.CH_W(CH_W)) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .iack_i(iack_i), .cfg_i(vec_cfg_i),
    .ivr_i(ivr_q), .ctx_kind_i(ctx_kind), .ctx_ch_i(ctx_ch),
    .ack_start_o(ack_start), .vec_oe_o(vec_oe_o), .vec_o(vec_o)
  );

  gwin_ctx_latch #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .CH_W(CH_W)) u_ctx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(capture),
    .kind_i(win_kind_i), .code_i(win_code_i), .ch_i(win_ch_i),
    .tx_lvl_i(tx_empty_lvl_i), .rx_lvl_i(rx_fill_lvl_i),
    .ctx_kind_o(ctx_kind), .ctx_code_o(ctx_code), .ctx_ch_o(ctx_ch),
    .ctx_count_o(ctx_count)
  );

  gwin_fifo_steer #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_steer (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(reg_addr_i), .rd_i(reg_rd_i),
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .ctx_ch_i(ctx_ch),
    .rx_data_i(rx_data_i), .char_len_i(char_len_i),
    .rx_pop_o(rx_pop_o), .tx_push_o(tx_push_o), .tx_wdata_o(tx_wdata_o),
    .rx_byte_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ivr_q <= 8'h00;
    else if (reg_wr_i && reg_addr_i == A_VECTOR)   ivr_q <= reg_wdata_i;
  end

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_rd_i) begin
      case (reg_addr_i)
        A_CHAN:   reg_rdata_o = 8'(ctx_ch);
        A_COUNT:  reg_rdata_o = ctx_count;
        A_TYPE:   reg_rdata_o = type_byte(ctx_kind, ctx_code);
        A_RXPORT: reg_rdata_o = rx_byte;
        A_VECTOR: reg_rdata_o = ivr_q;
        default:  reg_rdata_o = 8'h00;
      endcase
    end
  end

  AST_CHAN_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_CHAN) |-> reg_rdata_o[7:1] == 7'd0); // R3
  AST_TYPE_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_TYPE) |-> reg_rdata_o[4:3] == 2'b00); // R5

endmodule

// File: tb/gwin_ctx_window_tb.sv
module gwin_ctx_window_tb_top;

  localparam int NUM_CH = 2;
  localparam int LVL_W  = 9;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    ucir = 1'b0, iack = 1'b0;
  logic [1:0]              vcfg = 2'b00;
  logic [1:0]              wkind = 2'b00;
  logic [2:0]              wcode = 3'd0;
  logic                    wch = 1'b0;
  logic [NUM_CH*LVL_W-1:0] txl = '0, rxl = '0;
  logic [NUM_CH*2-1:0]     clen = '0;
  logic [NUM_CH*8-1:0]     rxd = '0;
  logic [2:0]              addr = 3'd0;
  logic                    rd = 1'b0, wr = 1'b0;
  logic [7:0]              wdata = 8'h00;
  logic [7:0]              rdata, txw, vec;
  logic [NUM_CH-1:0]       pop, push;
  logic                    voe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gwin_ctx_window dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ucir_i(ucir), .iack_i(iack), .vec_cfg_i(vcfg),
    .win_kind_i(wkind), .win_code_i(wcode), .win_ch_i(wch),
    .tx_empty_lvl_i(txl), .rx_fill_lvl_i(rxl), .char_len_i(clen), .rx_data_i(rxd),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rx_pop_o(pop), .tx_push_o(push), .tx_wdata_o(txw),
    .vec_oe_o(voe), .vec_o(vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d, output logic [1:0] p);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata; p = pop;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, output logic [1:0] p, output logic [7:0] w);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1 p = push; w = txw;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic capture(input logic [1:0] k, input logic [2:0] c, input logic ch);
    @(negedge clk);
    wkind = k; wcode = c; wch = ch; ucir = 1'b1;
    @(negedge clk);
    ucir = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [1:0] p;
    rd_reg(3'd0, d, p); check("R1 chan", d, 8'h00);
    rd_reg(3'd1, d, p); check("R1 count", d, 8'h00);
    rd_reg(3'd2, d, p); check("R1 type", d, 8'h00);
    rd_reg(3'd5, d, p); check("R1 vector reg", d, 8'h00);
    check("R1 vec_oe", voe, 1'b0);
  endtask

  task automatic t_tx_context();
    logic [7:0] d; logic [1:0] p;
    txl = {9'd37, 9'd5};
    capture(2'b01, 3'd0, 1'b1);
    rd_reg(3'd0, d, p); check("R3 chan=1", d, 8'h01);
    rd_reg(3'd1, d, p); check("R4 tx level", d, 8'd37);
    rd_reg(3'd2, d, p); check("R5 tx type", d, 8'h20);
    // change inputs without capture: context must hold
    @(negedge clk);
    txl = {9'd99, 9'd1}; wkind = 2'b11; wch = 1'b0;
    rd_reg(3'd1, d, p); check("R4 count frozen", d, 8'd37);
    rd_reg(3'd0, d, p); check("R2 chan frozen", d, 8'h01);
  endtask

  task automatic t_rx_counts();
    logic [7:0] d; logic [1:0] p;
    rxl = {9'd255, 9'd256};
    capture(2'b10, 3'd0, 1'b0);
    rd_reg(3'd1, d, p); check("R4 256 -> 0x00", d, 8'h00);
    rd_reg(3'd2, d, p); check("R5 rx ok type", d, 8'hC0);
    capture(2'b11, 3'd0, 1'b1);
    rd_reg(3'd1, d, p); check("R4 rx 255", d, 8'hFF);
    rd_reg(3'd2, d, p); check("R5 rx err type", d, 8'h80);
    capture(2'b00, 3'd5, 1'b1);
    rd_reg(3'd2, d, p); check("R5 other type", d, 8'h05);
    rd_reg(3'd1, d, p); check("R4 other count", d, 8'h00);
  endtask

  task automatic t_rx_port();
    logic [7:0] d; logic [1:0] p;
    rxd = {8'hFF, 8'hAA};
    capture(2'b10, 3'd0, 1'b1);
    for (int l = 0; l < 4; l++) begin
      clen = {2'(l), 2'b11};
      rd_reg(3'd3, d, p);
      check("R6 rx masked", d, 8'hFF >> (3 - l));
      check("R6 pop ch1", p, 2'b10);
    end
    capture(2'b10, 3'd0, 1'b0);
    clen = {2'b11, 2'b00};
    rd_reg(3'd3, d, p);
    check("R6 rx ch0 5-bit", d, 8'h0A);
    check("R6 pop ch0", p, 2'b01);
    rd_reg(3'd1, d, p);
    check("R6 no pop on count read", p, 2'b00);
  endtask

  task automatic t_tx_port();
    logic [1:0] p; logic [7:0] w;
    capture(2'b01, 3'd0, 1'b1);
    wr_reg(3'd4, 8'h5A, p, w);
    check("R7 push ch1", p, 2'b10); check("R7 wdata", w, 8'h5A);
    capture(2'b01, 3'd0, 1'b0);
    wr_reg(3'd4, 8'hC3, p, w);
    check("R7 push ch0", p, 2'b01); check("R7 wdata ch0", w, 8'hC3);
    wr_reg(3'd5, 8'hB5, p, w);
    check("R7 no push on vector write", p, 2'b00);
  endtask

  task automatic t_vector();
    logic [7:0] d; logic [1:0] p;
    rd_reg(3'd5, d, p); check("R8 vector reg", d, 8'hB5);
    // cfg 01, acknowledge with tx on ch0: context captured at ack start
    vcfg = 2'b01;
    @(negedge clk);
    wkind = 2'b01; wch = 1'b0; iack = 1'b1;
    #1 check("R13 no drive before edge", voe, 1'b0);
    @(negedge clk); #1;
    check("R10 oe", voe, 1'b1); check("R10 unmodified", vec, 8'hB5);
    vcfg = 2'b10; #1 check("R11 chan patch", vec, 8'hB4);
    vcfg = 2'b11; #1 check("R12 kind+chan", vec, 8'hB2);
    // change arbiter inputs while ack held: no recapture
    @(negedge clk);
    wkind = 2'b11; wch = 1'b1;
    @(negedge clk); #1;
    check("R2 held ack no recapture", vec, 8'hB2);
    vcfg = 2'b00; #1 check("R9 no drive", voe, 1'b0);
    @(negedge clk);
    iack = 1'b0; vcfg = 2'b11;
    @(negedge clk); #1;
    check("R13 released after ack", voe, 1'b0);
    // second ack with rx-err on ch1
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk); #1;
    check("R12 new ack kind+chan", vec, 8'hB7);
    @(negedge clk);
    iack = 1'b0;
    rd_reg(3'd0, d, p); check("R2 ack captured chan", d, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_context();
    t_rx_counts();
    t_rx_port();
    t_tx_port();
    t_vector();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule